// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns an inbound PCI DMA bus address into a host physical address. Software sets up four windows. Each window has three registers: a base register holding the address field and two flags, a size mask, and a translation base. For each lookup the block finds the lowest-numbered enabled window that claims the address. A direct window answers with a plain offset. A scatter-gather window turns the offset into a page index and reads an 8-byte page entry from a page-table memory through a one-request read port. The physical frame is taken from that entry.

Recent scatter-gather translations are kept in a four-entry fully associative cache that is refilled in round-robin order. Writing the invalidate register code empties the cache. Software is expected to write it both before and after it changes any window. Every lookup gets exactly one response carrying a status (OK, FAULT or MISS) and, for OK, the physical address. Only one page-table fetch can be outstanding, so `req_ready` is low while a fetch is in flight.

Top module: `dwt_xlat`

## Requirements
- R1: After reset all window registers are zero, so every window is disabled. `req_ready` is high, `rsp_valid` and `pt_rd_req` are low, and any lookup answers MISS.
- R2: The configuration register codes are: 0 = base, 1 = mask, 2 = translation base, 3 = invalidate all. In the base register, bit 0 is enable, bit 1 selects scatter-gather, and bits 31:20 hold the address. The mask keeps only bits 31:20. A window claims an address when it is enabled and the address equals its base on every field bit the mask does not cover. When several windows claim the address, the lowest-numbered one wins.
- R3: When no enabled window claims the address, `rsp_valid` rises the cycle after the request is accepted, with status MISS (2) and a physical address of zero.
- R4: A direct window answers the cycle after acceptance with status OK (0) and a physical address equal to the bus address minus the window base, zero-extended.
- R5: A scatter-gather lookup that misses the cache raises `pt_rd_req` for one cycle, the cycle after acceptance. The read address is the translation base plus 8 × ((bus address − window base) / 8192). `req_ready` stays low until the response.
- R6: The cycle after `pt_rd_valid`, an entry with bit 0 set produces status OK. The physical address is the entry shifted right by one, placed above bus-address bits 12:0, which pass through unchanged.
- R7: An entry with bit 0 clear produces status FAULT (1) with a physical address of zero, and it is not cached. A repeated lookup of the same page fetches again.
- R8: A scatter-gather lookup that hits a cached page answers the cycle after acceptance with no fetch. The cache holds four pages and replaces them in round-robin order.
- R9: An invalidate write empties the cache. If it lands in the same cycle as a returning entry, the lookup is still answered, but the page is not cached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window selected by the write |
| cfg_reg | input | 2 | Register code: 0 base, 1 mask, 2 translation base, 3 invalidate |
| cfg_wdata | input | 40 | Write data |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block can accept a lookup |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_status | output | 2 | 0 OK, 1 FAULT, 2 MISS |
| rsp_paddr | output | 40 | Physical address, zero unless OK |
| pt_rd_req | output | 1 | Page-entry read request, one cycle |
| pt_rd_addr | output | 40 | Page-entry address |
| pt_rd_valid | input | 1 | Page-entry data is present |
| pt_rd_data | input | 28 | Page entry: bit 0 valid, bits 27:1 frame |

## Verification
Two events can land on the same clock edge: the page-table read returning and an invalidate write that flushes the cache. The bench forces this by driving the invalidate register write in the exact cycle it drives `pt_rd_valid`. It then checks two things: the lookup still gets a correct OK response, and a repeat lookup of the same page produces a fresh `pt_rd_req` rather than a cache hit. A second case, window priority, is provoked by programming window 3 over the same range as window 1. The bench confirms that the lower-numbered window answers, and that window 3 only answers once window 1 is cleared.

// File: rtl/dwt_pkg.sv
// Shared encodings for the DMA window translator.
// Assumes: status and register codes are fixed by the block's interface.
package dwt_pkg;
    typedef enum logic [1:0] {
        XST_OK    = 2'd0,
        XST_FAULT = 2'd1,
        XST_MISS  = 2'd2
    } xlat_status_e;

    localparam logic [1:0] CREG_BASE  = 2'd0;
    localparam logic [1:0] CREG_MASK  = 2'd1;
    localparam logic [1:0] CREG_TBASE = 2'd2;
    localparam logic [1:0] CREG_INVAL = 2'd3;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xlat_state_e;
endpackage

// File: rtl/dwt_window_regs.sv
// Holds the base, mask and translation-base register of each window.
// It also decodes the invalidate-all strobe.
// Assumes: the mask is stored with only its address-field bits kept.
module dwt_window_regs
    import dwt_pkg::*;
#(
    parameter int NUM_WIN   = 4,
    parameter int ABITS     = 32,
    parameter int PBITS     = 40,
    parameter int FIELD_LSB = 20
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_wr,
    input  logic [$clog2(NUM_WIN)-1:0]        cfg_win,
    input  logic [1:0]                        cfg_reg,
    input  logic [PBITS-1:0]                  cfg_wdata,
    output logic [NUM_WIN-1:0][ABITS-1:0]     base_q,
    output logic [NUM_WIN-1:0][ABITS-1:0]     mask_q,
    output logic [NUM_WIN-1:0][PBITS-1:0]     tbase_q,
    output logic                              inval
);
    localparam int WSEL = $clog2(NUM_WIN);
    localparam logic [ABITS-1:0] FIELD_MASK =
        {{(ABITS-FIELD_LSB){1'b1}}, {FIELD_LSB{1'b0}}};

    // Invalidate strobe: a write to the invalidate code, any window.
    assign inval = cfg_wr && (cfg_reg == CREG_INVAL);

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        logic sel;
        assign sel = cfg_wr && (cfg_win == WSEL'(w));

        // Register update for one window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[w]  <= '0;
                mask_q[w]  <= '0;
                tbase_q[w] <= '0;
            end else if (sel) begin
                case (cfg_reg)
                    CREG_BASE:  base_q[w]  <= cfg_wdata[ABITS-1:0];
                    CREG_MASK:  mask_q[w]  <= cfg_wdata[ABITS-1:0] & FIELD_MASK;
                    CREG_TBASE: tbase_q[w] <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dwt_window_match.sv
// Compares a bus address against every window and picks the
// lowest-numbered enabled window that claims it.
// Assumes: bit 0 of a base register enables the window, bit 1 selects
// scatter-gather, and bits from FIELD_LSB upward carry the address.
module dwt_window_match #(
    parameter int NUM_WIN   = 4,
    parameter int ABITS     = 32,
    parameter int PBITS     = 40,
    parameter int FIELD_LSB = 20
) (
    input  logic [ABITS-1:0]              addr,
    input  logic [NUM_WIN-1:0][ABITS-1:0] base_q,
    input  logic [NUM_WIN-1:0][ABITS-1:0] mask_q,
    input  logic [NUM_WIN-1:0][PBITS-1:0] tbase_q,
    output logic                          found,
    output logic                          sel_sg,
    output logic [ABITS-1:0]              sel_base,
    output logic [PBITS-1:0]              sel_tbase
);
    localparam int WSEL = $clog2(NUM_WIN);
    localparam logic [ABITS-1:0] FIELD_MASK =
        {{(ABITS-FIELD_LSB){1'b1}}, {FIELD_LSB{1'b0}}};

    logic [NUM_WIN-1:0] claim;
    logic [WSEL-1:0]    idx;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        // Per-window claim: enabled and equal on every unmasked field bit.
        assign claim[w] = base_q[w][0] &&
            (((addr ^ base_q[w]) & ~mask_q[w] & FIELD_MASK) == '0);
    end

    // Priority pick: scanning downward leaves the lowest claimer.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (claim[w]) begin
                found = 1'b1;
                idx   = WSEL'(w);
            end
        end
    end

    assign sel_sg    = base_q[idx][1];
    assign sel_base  = base_q[idx] & FIELD_MASK;
    assign sel_tbase = tbase_q[idx];
endmodule

// File: rtl/dwt_tlb.sv
// Small fully associative translation cache with round-robin fill.
// Assumes: a fill never repeats a tag already present, since fills only
// follow misses. Invalidate takes priority over a fill in the same cycle.
module dwt_tlb #(
    parameter int ENTRIES = 4,
    parameter int TAGW    = 19,
    parameter int DATAW   = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAGW-1:0]  lk_tag,
    output logic             lk_hit,
    output logic [DATAW-1:0] lk_data,
    input  logic             fill_en,
    input  logic [TAGW-1:0]  fill_tag,
    input  logic [DATAW-1:0] fill_data,
    input  logic             inval
);
    localparam int RRW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][TAGW-1:0]  tag_q;
    logic [ENTRIES-1:0][DATAW-1:0] data_q;
    logic [RRW-1:0]                rr_q;

    // Associative search over all entries.
    always_comb begin
        lk_hit  = 1'b0;
        lk_data = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (valid_q[e] && (tag_q[e] == lk_tag)) begin
                lk_hit  = 1'b1;
                lk_data = data_q[e];
            end
        end
    end

    // Flush, or fill at the round-robin pointer and advance it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            tag_q   <= '0;
            data_q  <= '0;
            rr_q    <= '0;
        end else if (inval) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[rr_q] <= 1'b1;
            tag_q[rr_q]   <= fill_tag;
            data_q[rr_q]  <= fill_data;
            rr_q          <= (rr_q == RRW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/dwt_xlat.sv
// DMA window translator top. It accepts one lookup at a time and answers
// directly, from the cache, or after a single page-entry fetch.
// Assumes: pt_rd_valid is driven only while a fetch is outstanding, and
// page entries are 8 bytes apart.
module dwt_xlat
    import dwt_pkg::*;
#(
    parameter int NUM_WIN     = 4,
    parameter int ABITS       = 32,
    parameter int PBITS       = 40,
    parameter int PAGE_SHIFT  = 13,
    parameter int FIELD_LSB   = 20,
    parameter int TLB_ENTRIES = 4,
    parameter int PTE_SHIFT   = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_wr,
    input  logic [$clog2(NUM_WIN)-1:0]  cfg_win,
    input  logic [1:0]                  cfg_reg,
    input  logic [PBITS-1:0]            cfg_wdata,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ABITS-1:0]            req_addr,
    output logic                        rsp_valid,
    output logic [1:0]                  rsp_status,
    output logic [PBITS-1:0]            rsp_paddr,
    output logic                        pt_rd_req,
    output logic [PBITS-1:0]            pt_rd_addr,
    input  logic                        pt_rd_valid,
    input  logic [PBITS-PAGE_SHIFT:0]   pt_rd_data
);
    localparam int PFNW = PBITS - PAGE_SHIFT;
    localparam int TAGW = ABITS - PAGE_SHIFT;

    logic [NUM_WIN-1:0][ABITS-1:0] base_q;
    logic [NUM_WIN-1:0][ABITS-1:0] mask_q;
    logic [NUM_WIN-1:0][PBITS-1:0] tbase_q;
    logic                          inval;
    logic                          found, sel_sg;
    logic [ABITS-1:0]              sel_base, offset;
    logic [PBITS-1:0]              sel_tbase, vpn_ext;
    logic                          tlb_hit, fill_en;
    logic [PFNW-1:0]               tlb_pfn;
    xlat_state_e                   state_q;
    logic [TAGW-1:0]               pend_tag_q;
    logic [PAGE_SHIFT-1:0]         pend_off_q;
    logic                          accept;

    dwt_window_regs #(
        .NUM_WIN(NUM_WIN), .ABITS(ABITS), .PBITS(PBITS), .FIELD_LSB(FIELD_LSB)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_win(cfg_win),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .base_q(base_q),
        .mask_q(mask_q), .tbase_q(tbase_q), .inval(inval)
    );

    dwt_window_match #(
        .NUM_WIN(NUM_WIN), .ABITS(ABITS), .PBITS(PBITS), .FIELD_LSB(FIELD_LSB)
    ) u_match (
        .addr(req_addr), .base_q(base_q), .mask_q(mask_q), .tbase_q(tbase_q),
        .found(found), .sel_sg(sel_sg), .sel_base(sel_base),
        .sel_tbase(sel_tbase)
    );

    dwt_tlb #(
        .ENTRIES(TLB_ENTRIES), .TAGW(TAGW), .DATAW(PFNW)
    ) u_tlb (
        .clk(clk), .rst_n(rst_n), .lk_tag(req_addr[ABITS-1:PAGE_SHIFT]),
        .lk_hit(tlb_hit), .lk_data(tlb_pfn), .fill_en(fill_en),
        .fill_tag(pend_tag_q), .fill_data(pt_rd_data[PFNW:1]), .inval(inval)
    );

    // Handshake and offset arithmetic for the claimed window.
    assign req_ready = (state_q == XS_IDLE);
    assign accept    = req_valid && req_ready;
    assign offset    = req_addr - sel_base;
    assign vpn_ext   = PBITS'(offset >> PAGE_SHIFT);
    assign fill_en   = (state_q == XS_WAIT) && pt_rd_valid && pt_rd_data[0];

    // Lookup sequencing: immediate answer, or one fetch and then an answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= XS_IDLE;
            rsp_valid  <= 1'b0;
            rsp_status <= XST_OK;
            rsp_paddr  <= '0;
            pt_rd_req  <= 1'b0;
            pt_rd_addr <= '0;
            pend_tag_q <= '0;
            pend_off_q <= '0;
        end else begin
            rsp_valid <= 1'b0;
            pt_rd_req <= 1'b0;
            if (accept) begin
                if (!found) begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= XST_MISS;
                    rsp_paddr  <= '0;
                end else if (!sel_sg) begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= XST_OK;
                    rsp_paddr  <= PBITS'(offset);
                end else if (tlb_hit) begin
                    rsp_valid  <= 1'b1;
                    rsp_status <= XST_OK;
                    rsp_paddr  <= {tlb_pfn, req_addr[PAGE_SHIFT-1:0]};
                end else begin
                    pt_rd_req  <= 1'b1;
                    pt_rd_addr <= sel_tbase + (vpn_ext << PTE_SHIFT);
                    pend_tag_q <= req_addr[ABITS-1:PAGE_SHIFT];
                    pend_off_q <= req_addr[PAGE_SHIFT-1:0];
                    state_q    <= XS_WAIT;
                end
            end else if ((state_q == XS_WAIT) && pt_rd_valid) begin
                rsp_valid <= 1'b1;
                state_q   <= XS_IDLE;
                if (pt_rd_data[0]) begin
                    rsp_status <= XST_OK;
                    rsp_paddr  <= {pt_rd_data[PFNW:1], pend_off_q};
                end else begin
                    rsp_status <= XST_FAULT;
                    rsp_paddr  <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/dwt_xlat_chk.sv
// Protocol checker for the DMA window translator, bound to its top.
// Assumes: the same synchronous active-low reset as the design.
module dwt_xlat_chk #(
    parameter int PBITS      = 40,
    parameter int PAGE_SHIFT = 13
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [PAGE_SHIFT-1:0] req_off,
    input logic                  rsp_valid,
    input logic [1:0]            rsp_status,
    input logic [PBITS-1:0]      rsp_paddr,
    input logic                  pt_rd_req,
    input logic                  pt_rd_valid
);
    logic [PAGE_SHIFT-1:0] held_off;

    // Remember the page offset of the lookup in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)                      held_off <= '0;
        else if (req_valid && req_ready) held_off <= req_off;
    end

    assert_fetch_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_req |=> !pt_rd_req);
    assert_busy_while_fetching_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rd_req |-> !req_ready);
    assert_accept_answered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || pt_rd_req));
    assert_rsp_fetch_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && pt_rd_req));
    assert_zero_addr_on_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));
    assert_entry_answered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_rd_valid && !req_ready) |=> rsp_valid);
    assert_offset_passthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0) |-> (rsp_paddr[PAGE_SHIFT-1:0] == held_off));
    assert_status_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_status != 2'd3));
endmodule

bind dwt_xlat dwt_xlat_chk #(.PBITS(PBITS), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_off(req_addr[PAGE_SHIFT-1:0]), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .pt_rd_req(pt_rd_req),
    .pt_rd_valid(pt_rd_valid)
);

// File: tb/tb_dwt_xlat.sv
// Bench for dwt_xlat. A behavioural model (window table, cache list,
// round-robin counter) predicts every cycle; outputs are compared at negedge.
module tb_dwt_xlat;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam longint unsigned FIELD = 64'hFFF0_0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_win = '0, cfg_reg = '0;
    logic [39:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [39:0] rsp_paddr;
    logic        pt_rd_req;
    logic [39:0] pt_rd_addr;
    logic        pt_rd_valid = 1'b0;
    logic [27:0] pt_rd_data = '0;

    int n_checks = 0, n_errs = 0;
    bit finished = 0;

    longint unsigned m_base[4], m_mask[4], m_tbase[4];
    longint unsigned m_tag[4], m_frm[4];
    bit              m_val[4];
    int              m_rr = 0;

    dwt_xlat dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_win(cfg_win),
        .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr), .pt_rd_req(pt_rd_req),
        .pt_rd_addr(pt_rd_addr), .pt_rd_valid(pt_rd_valid), .pt_rd_data(pt_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Page table contents: frame derived from entry address; every 16th invalid.
    function automatic logic [27:0] pte_of(input longint unsigned a);
        longint unsigned idx = a >> 3;
        logic [26:0] frm = 27'((idx * 7 + 5) & 64'h7FF_FFFF);
        return {frm, ((idx % 16) != 15) ? 1'b1 : 1'b0};
    endfunction

    task automatic idle_cycle(input string req);
        @(negedge clk);
        chk(rsp_valid == 1'b0, req, "rsp_valid idle", rsp_valid, 0);
        chk(pt_rd_req == 1'b0, req, "pt_rd_req idle", pt_rd_req, 0);
    endtask

    task automatic cfg_write(input int w, input int r, input longint unsigned d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_win = 2'(w); cfg_reg = 2'(r); cfg_wdata = 40'(d);
        @(negedge clk);
        cfg_wr = 1'b0;
        case (r)
            0: m_base[w]  = d & 64'hFFFF_FFFF;
            1: m_mask[w]  = d & FIELD;
            2: m_tbase[w] = d & 64'hFF_FFFF_FFFF;
            default: for (int e = 0; e < 4; e++) m_val[e] = 0;
        endcase
        chk(rsp_valid == 1'b0, "R2", "no response on cfg write", rsp_valid, 0);
    endtask

    // One lookup, checked cycle by cycle against the model.
    task automatic lookup(input longint unsigned a, input bit inv_at_fill,
                          input string req, input int exp_kind);
        int w_sel = -1;
        int kind;
        longint unsigned off, exp_pa = 0, exp_pt = 0;
        int hit_e = -1;
        logic [27:0] pte;
        for (int w = 0; w < 4; w++)
            if (w_sel < 0 && m_base[w][0] &&
                (((a ^ m_base[w]) & ~m_mask[w] & FIELD) == 0)) w_sel = w;
        if (w_sel < 0) kind = 0;
        else begin
            off = (a - (m_base[w_sel] & FIELD)) & 64'hFFFF_FFFF;
            if (!m_base[w_sel][1]) begin kind = 1; exp_pa = off; end
            else begin
                for (int e = 0; e < 4; e++)
                    if (m_val[e] && m_tag[e] == (a >> 13)) hit_e = e;
                if (hit_e >= 0) begin
                    kind = 2; exp_pa = (m_frm[hit_e] << 13) | (a & 64'h1FFF);
                end else begin
                    kind = 3;
                    exp_pt = (m_tbase[w_sel] + ((off >> 13) << 3)) & 64'hFF_FFFF_FFFF;
                end
            end
        end
        if (exp_kind >= 0)
            chk(kind == exp_kind, req, "model path", kind, exp_kind);
        @(negedge clk);
        chk(req_ready == 1'b1, req, "req_ready before lookup", req_ready, 1);
        req_valid = 1'b1; req_addr = 32'(a);
        @(negedge clk);
        req_valid = 1'b0;
        if (kind != 3) begin
            chk(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
            chk(pt_rd_req == 1'b0, req, "no fetch", pt_rd_req, 0);
            chk(rsp_status == ((kind == 0) ? 2'd2 : 2'd0), req, "status", rsp_status,
                (kind == 0) ? 2 : 0);
            chk(rsp_paddr == 40'(exp_pa), req, "paddr", rsp_paddr, exp_pa);
        end else begin
            chk(rsp_valid == 1'b0, req, "no early rsp", rsp_valid, 0);
            chk(pt_rd_req == 1'b1, req, "fetch pulse", pt_rd_req, 1);
            chk(pt_rd_addr == 40'(exp_pt), req, "entry address", pt_rd_addr, exp_pt);
            chk(req_ready == 1'b0, req, "busy during fetch", req_ready, 0);
            for (int c = 1; c < MEM_LAT; c++) idle_cycle(req);
            pte = pte_of(exp_pt);
            pt_rd_valid = 1'b1; pt_rd_data = pte;
            if (inv_at_fill) begin cfg_wr = 1'b1; cfg_reg = 2'd3; end
            @(negedge clk);
            pt_rd_valid = 1'b0; cfg_wr = 1'b0;
            chk(rsp_valid == 1'b1, req, "rsp after entry", rsp_valid, 1);
            if (pte[0]) begin
                exp_pa = (longint'(pte[27:1]) << 13) | (a & 64'h1FFF);
                chk(rsp_status == 2'd0, req, "status OK", rsp_status, 0);
            end else begin
                exp_pa = 0;
                chk(rsp_status == 2'd1, req, "status FAULT", rsp_status, 1);
            end
            chk(rsp_paddr == 40'(exp_pa), req, "paddr", rsp_paddr, exp_pa);
            chk(req_ready == 1'b1, req, "ready after rsp", req_ready, 1);
            if (inv_at_fill) for (int e = 0; e < 4; e++) m_val[e] = 0;
            else if (pte[0]) begin
                m_tag[m_rr] = a >> 13; m_frm[m_rr] = longint'(pte[27:1]);
                m_val[m_rr] = 1; m_rr = (m_rr + 1) % 4;
            end
        end
        idle_cycle(req);
    endtask

    initial begin
        for (int w = 0; w < 4; w++) begin m_base[w] = 0; m_mask[w] = 0; m_tbase[w] = 0; end
        for (int e = 0; e < 4; e++) begin m_val[e] = 0; m_tag[e] = 0; m_frm[e] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and an all-disabled miss
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
        chk(pt_rd_req == 1'b0, "R1", "pt_rd_req after reset", pt_rd_req, 0);
        lookup(64'h8000_0000, 0, "R1", 0);

        // R2: program the usual layout, flushing before and after
        cfg_write(0, 3, 0);
        cfg_write(0, 0, 64'h0080_0003); cfg_write(0, 1, 64'h007F_FFFF);
        cfg_write(0, 2, 64'h10_0000_0000);
        cfg_write(1, 0, 64'h8000_0001); cfg_write(1, 1, 64'h3FFF_FFFF);
        cfg_write(1, 2, 0);
        cfg_write(2, 0, 64'hC000_0003); cfg_write(2, 1, 64'h3FFF_FFFF);
        cfg_write(2, 2, 64'h20_0000_0000);
        cfg_write(3, 0, 0);
        cfg_write(0, 3, 0);

        // R3: misses, including window boundaries
        lookup(64'h0000_1234, 0, "R3", 0);
        lookup(64'h0100_0000, 0, "R3", 0);
        lookup(64'h7FFF_FFFF, 0, "R3", 0);
        // R4: direct window, first and last byte
        lookup(64'h8000_0000, 0, "R4", 1);
        lookup(64'h8123_4567, 0, "R4", 1);
        lookup(64'hBFFF_FFFF, 0, "R4", 1);
        // R5 R6: scatter-gather fetch, then R8 hit
        lookup(64'h0080_2010, 0, "R5", 3);
        lookup(64'h0080_2ABC, 0, "R8", 2);
        lookup(64'h00FF_FFFF, 0, "R6", 3);
        // R7: invalid entry faults and is not cached
        lookup(64'h0081_E000, 0, "R7", 3);
        lookup(64'h0081_E008, 0, "R7", 3);

        // R8: round-robin replacement over window 2 pages
        cfg_write(2, 3, 0);
        for (int k = 0; k < 5; k++) lookup(64'hC000_0000 + k * 64'h2000 + 16, 0, "R8", 3);
        for (int k = 0; k < 5; k++) lookup(64'hC000_0000 + k * 64'h2000 + 40, 0, "R8", -1);

        // R9: plain invalidate, then invalidate colliding with a fill
        lookup(64'hC010_0000, 0, "R9", 3);
        lookup(64'hC010_0004, 0, "R9", 2);
        cfg_write(1, 3, 0);
        lookup(64'hC010_0008, 0, "R9", 3);
        lookup(64'hC020_0000, 1, "R9", 3);
        lookup(64'hC020_0010, 0, "R9", 3);

        // R2: overlapping windows, lowest number wins
        cfg_write(3, 2, 64'h30_0000_0000);
        cfg_write(3, 1, 64'h007F_FFFF);
        cfg_write(3, 0, 64'h8000_0003);
        lookup(64'h8000_4000, 0, "R2", 1);
        cfg_write(1, 0, 0);
        lookup(64'h8000_4000, 0, "R2", 3);
        lookup(64'h8080_0000, 0, "R2", 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errs++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule